// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of a 16-bit NOR flash and turns one-word user requests into the write and read cycles the flash expects. A request may program one word, erase a sector, erase a block, erase the whole chip, or fetch the manufacturer and device identifiers. The controller emits the unlock writes and the command write. For program and erase requests it then polls the flash until the toggling status bit (data bit 6) settles. For an identifier fetch it waits a fixed access delay, reads the two identifier words and writes the exit command.

The flash bus is abstracted to one clock cycle per strobe. A cycle with `fl_wr` high is one flash write of `fl_wdata` to `fl_addr`. A cycle with `fl_rd` high is one flash read of `fl_addr`, and its data must be presented on `fl_rdata` during the following cycle. A request is accepted only while `busy` is low. Each accepted request ends with a one-cycle `done` pulse or a one-cycle `timeout` pulse.

States: IDLE (wait for request), CMD (one write per cycle from the command table), ID_WAIT (access delay), ID_RD/ID_CAP (identifier read and capture, address 0 then 1), ID_EXIT (exit write), POLL_RD/POLL_CAP (status read and compare), FINISH (done pulse), TOUT (timeout pulse). Transitions:
- IDLE→CMD on a valid request.
- CMD→ID_WAIT (identifier) or CMD→POLL_RD (program/erase) on the last table write.
- ID_WAIT→ID_RD after ID_WAIT cycles.
- ID_RD→ID_CAP.
- ID_CAP→ID_RD after the first word, ID_CAP→ID_EXIT after the second.
- ID_EXIT→FINISH.
- POLL_RD→POLL_CAP, or POLL_RD→TOUT when the limit expires.
- POLL_CAP→FINISH when completion is confirmed, POLL_CAP→TOUT when the limit expires, otherwise POLL_CAP→POLL_RD.
- FINISH→IDLE and TOUT→IDLE.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `timeout`, `fl_wr` and `fl_rd` are low, and no strobe is driven while `busy` is low.
- R2: Request code 0 (program) writes AAh@555h, 55h@2AAh, A0h@555h and then the request data at the request address, then polls that address.
- R3: Code 1 (sector erase), code 2 (block erase) and code 3 (chip erase) write AAh@555h, 55h@2AAh, 80h@555h, AAh@555h and 55h@2AAh, then a final write. The final write is 50h at the request address with its low SECT_BITS (default 11) bits cleared, 30h at the address with its low BLK_BITS (default 15) bits cleared, or 10h@555h.
- R4: At most one strobe is active per cycle: `fl_wr` and `fl_rd` are never high together.
- R5: Completion is declared only after two successive status reads return equal bit 6, followed by a further pair of reads that also agree with each other.
- R6: If the confirming pair disagrees (a coincidental match while the flash is still busy), polling resumes and no `done` is given.
- R7: Code 4 (identifier) writes AAh@555h, 55h@2AAh, 90h@555h, then waits ID_WAIT cycles. It reads address 0 into `id_mfr` and address 1 into `id_dev`, then writes F0h@0. The first read occurs ID_WAIT+1 cycles after the 90h write.
- R8: If completion is not seen within the polling limit for the operation type (PROG_LIMIT, ERASE_LIMIT for sector/block, CHIP_LIMIT), `timeout` pulses exactly that many cycles after the final command write. No `done` is given, and the block returns to idle.
- R9: While `busy` is high, requests are refused: no extra writes are issued and the current operation is not altered.
- R10: Request codes 5 to 7 are ignored: `busy` stays low and no flash cycle is issued.
- R11: `done` and `timeout` are single-cycle pulses and never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 identifier |
| req_addr | input | AW | Target word address |
| req_data | input | 16 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle polling-limit pulse |
| id_mfr | output | 16 | Captured manufacturer identifier |
| id_dev | output | 16 | Captured device identifier |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_rd |

## Verification
On every cycle, the assertions check the following:
- strobe exclusivity and quiet strobes while idle;
- pulse shape and exclusivity of `done` and `timeout`;
- that the operation register cannot change while busy;
- that a program or erase `done` follows a status capture;
- that the confirm phase is entered only from a sample;
- that the polling counter stays below its limit.

The exact command bytes and addresses, sector and block alignment, the identifier access delay, the timeout cycle count and the rejection of a spurious match can only be shown by the bench. It does this by replaying scenarios against a flash model that toggles bit 6 a set number of times, with an optional repeated value.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_PROG       = 3'd0,
        OP_ERASE_SECT = 3'd1,
        OP_ERASE_BLK  = 3'd2,
        OP_ERASE_CHIP = 3'd3,
        OP_READ_ID    = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ID_WAIT, S_ID_RD, S_ID_CAP, S_ID_EXIT,
        S_POLL_RD, S_POLL_CAP, S_FINISH, S_TOUT
    } ctrl_state_e;

    localparam logic [15:0] UNLOCK_ADDR1 = 16'h0555;
    localparam logic [15:0] UNLOCK_ADDR2 = 16'h02AA;
    localparam logic [15:0] KEY1         = 16'h00AA;
    localparam logic [15:0] KEY2         = 16'h0055;
    localparam logic [15:0] CMD_PROG     = 16'h00A0;
    localparam logic [15:0] CMD_ERASE    = 16'h0080;
    localparam logic [15:0] CMD_ID       = 16'h0090;
    localparam logic [15:0] CMD_EXIT     = 16'h00F0;
    localparam logic [15:0] CMD_SECT     = 16'h0050;
    localparam logic [15:0] CMD_BLK      = 16'h0030;
    localparam logic [15:0] CMD_CHIP     = 16'h0010;

    function automatic logic op_code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import flash_ctrl_pkg::*; #(
    parameter int AW        = 21,
    parameter int SECT_BITS = 11,
    parameter int BLK_BITS  = 15
) (
    input  op_e             op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [15:0]     tgt_data,
    output logic [AW-1:0]   cmd_addr,
    output logic [15:0]     cmd_data,
    output logic            cmd_last,
    output logic [AW-1:0]   poll_addr
);
    localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_BITS;
    localparam logic [AW-1:0] BLK_MASK  = {AW{1'b1}} << BLK_BITS;
    localparam logic [AW-1:0] A1 = AW'(UNLOCK_ADDR1);
    localparam logic [AW-1:0] A2 = AW'(UNLOCK_ADDR2);

    logic [AW-1:0] sect_addr;
    logic [AW-1:0] blk_addr;

    assign sect_addr = tgt_addr & SECT_MASK;
    assign blk_addr  = tgt_addr & BLK_MASK;

    always_comb begin
        cmd_addr = '0;
        cmd_data = '0;
        cmd_last = 1'b0;
        unique case (step)
            3'd0: begin cmd_addr = A1; cmd_data = KEY1; end
            3'd1: begin cmd_addr = A2; cmd_data = KEY2; end
            3'd2: begin
                cmd_addr = A1;
                unique case (op)
                    OP_PROG:    cmd_data = CMD_PROG;
                    OP_READ_ID: begin cmd_data = CMD_ID; cmd_last = 1'b1; end
                    default:    cmd_data = CMD_ERASE;
                endcase
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    cmd_addr = tgt_addr;
                    cmd_data = tgt_data;
                    cmd_last = 1'b1;
                end else begin
                    cmd_addr = A1;
                    cmd_data = KEY1;
                end
            end
            3'd4: begin cmd_addr = A2; cmd_data = KEY2; end
            3'd5: begin
                cmd_last = 1'b1;
                unique case (op)
                    OP_ERASE_SECT: begin cmd_addr = sect_addr; cmd_data = CMD_SECT; end
                    OP_ERASE_BLK:  begin cmd_addr = blk_addr;  cmd_data = CMD_BLK;  end
                    default:       begin cmd_addr = A1;        cmd_data = CMD_CHIP; end
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_PROG:       poll_addr = tgt_addr;
            OP_ERASE_SECT: poll_addr = sect_addr;
            OP_ERASE_BLK:  poll_addr = blk_addr;
            default:       poll_addr = '0;
        endcase
    end

endmodule

// File: rtl/flash_toggle_judge.sv
module flash_toggle_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic dq6,
    output logic complete
);
    logic have_prev;
    logic prev_bit;
    logic confirm;

    assign complete = sample && confirm && have_prev && (dq6 == prev_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            confirm   <= 1'b0;
        end else if (clear) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            confirm   <= 1'b0;
        end else if (sample) begin
            if (!have_prev) begin
                have_prev <= 1'b1;
                prev_bit  <= dq6;
            end else if (!confirm) begin
                if (dq6 == prev_bit) begin
                    confirm   <= 1'b1;
                    have_prev <= 1'b0;
                end else begin
                    prev_bit  <= dq6;
                end
            end else if (dq6 != prev_bit) begin
                confirm   <= 1'b0;
                prev_bit  <= dq6;
            end
        end
    end

    // R6: the confirm phase is entered only on a status sample
    assert_confirm_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(confirm) |-> $past(sample));

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = run && (cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= cnt + 1'b1;
    end

    // R8: polling never runs past the selected limit
    assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl import flash_ctrl_pkg::*; #(
    parameter int AW          = 21,
    parameter int SECT_BITS   = 11,
    parameter int BLK_BITS    = 15,
    parameter int ID_WAIT     = 3,
    parameter int PROG_LIMIT  = 64,
    parameter int ERASE_LIMIT = 200,
    parameter int CHIP_LIMIT  = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [15:0]   id_mfr,
    output logic [15:0]   id_dev,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_wdata,
    input  logic [15:0]   fl_rdata
);
    localparam int MAX_LIMIT = (CHIP_LIMIT > ERASE_LIMIT)
        ? ((CHIP_LIMIT > PROG_LIMIT) ? CHIP_LIMIT : PROG_LIMIT)
        : ((ERASE_LIMIT > PROG_LIMIT) ? ERASE_LIMIT : PROG_LIMIT);
    localparam int TW = $clog2(MAX_LIMIT + 1);
    localparam int WW = $clog2(ID_WAIT + 1);

    ctrl_state_e   state, state_nx;
    op_e           cur_op;
    logic [AW-1:0] cur_addr;
    logic [15:0]   cur_data;
    logic [2:0]    step;
    logic [WW-1:0] wait_cnt;
    logic          id_sel;

    logic [AW-1:0] cmd_addr, poll_addr;
    logic [15:0]   cmd_data;
    logic          cmd_last;
    logic          complete, expired, accept;
    logic [TW-1:0] limit;

    assign accept = (state == S_IDLE) && req_valid && op_code_ok(req_op);

    flash_cmd_seq #(.AW(AW), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)) i_cmd (
        .op(cur_op), .step(step), .tgt_addr(cur_addr), .tgt_data(cur_data),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last),
        .poll_addr(poll_addr)
    );

    flash_toggle_judge i_judge (
        .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE),
        .sample(state == S_POLL_CAP), .dq6(fl_rdata[6]), .complete(complete)
    );

    always_comb begin
        unique case (cur_op)
            OP_PROG:       limit = TW'(PROG_LIMIT);
            OP_ERASE_CHIP: limit = TW'(CHIP_LIMIT);
            default:       limit = TW'(ERASE_LIMIT);
        endcase
    end

    flash_op_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE),
        .run((state == S_POLL_RD) || (state == S_POLL_CAP)),
        .limit(limit), .expired(expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (accept) state_nx = S_CMD;
            S_CMD:      if (cmd_last)
                            state_nx = (cur_op == OP_READ_ID) ? S_ID_WAIT : S_POLL_RD;
            S_ID_WAIT:  if (wait_cnt == WW'(ID_WAIT - 1)) state_nx = S_ID_RD;
            S_ID_RD:    state_nx = S_ID_CAP;
            S_ID_CAP:   state_nx = id_sel ? S_ID_EXIT : S_ID_RD;
            S_ID_EXIT:  state_nx = S_FINISH;
            S_POLL_RD:  state_nx = expired ? S_TOUT : S_POLL_CAP;
            S_POLL_CAP: begin
                if (complete)     state_nx = S_FINISH;
                else if (expired) state_nx = S_TOUT;
                else              state_nx = S_POLL_RD;
            end
            S_FINISH:   state_nx = S_IDLE;
            S_TOUT:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op   <= OP_PROG;
            cur_addr <= '0;
            cur_data <= '0;
            step     <= '0;
            wait_cnt <= '0;
            id_sel   <= 1'b0;
            id_mfr   <= '0;
            id_dev   <= '0;
        end else begin
            if (accept) begin
                cur_op   <= op_e'(req_op);
                cur_addr <= req_addr;
                cur_data <= req_data;
                step     <= '0;
                wait_cnt <= '0;
                id_sel   <= 1'b0;
            end
            if (state == S_CMD)     step     <= step + 1'b1;
            if (state == S_ID_WAIT) wait_cnt <= wait_cnt + 1'b1;
            if (state == S_ID_CAP) begin
                if (!id_sel) begin
                    id_mfr <= fl_rdata;
                    id_sel <= 1'b1;
                end else begin
                    id_dev <= fl_rdata;
                end
            end
        end
    end

    // outputs
    always_comb begin
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state)
            S_CMD:     begin fl_wr = 1'b1; fl_addr = cmd_addr; fl_wdata = cmd_data; end
            S_ID_EXIT: begin fl_wr = 1'b1; fl_addr = '0; fl_wdata = CMD_EXIT; end
            S_ID_RD:   begin fl_rd = 1'b1; fl_addr = AW'(id_sel); end
            S_POLL_RD: begin fl_rd = 1'b1; fl_addr = poll_addr; end
            default: ;
        endcase
        busy    = (state != S_IDLE);
        done    = (state == S_FINISH);
        timeout = (state == S_TOUT);
    end

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_wr && !fl_rd));
    assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_tout_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
    assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_op));
    assert_done_from_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op != OP_READ_ID) |-> $past(state == S_POLL_CAP));

endmodule

// File: tb/test_flash_seq_ctrl.sv
module test_flash_seq_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int AW          = 21;
    localparam int ID_WAIT     = 3;
    localparam int PROG_LIMIT  = 64;
    localparam int ERASE_LIMIT = 200;
    localparam logic [15:0] MFR_VAL = 16'h00C2;
    localparam logic [15:0] DEV_VAL = 16'h5A17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic busy, done, timeout, fl_wr, fl_rd;
    logic [15:0] id_mfr, id_dev, fl_wdata;
    logic [AW-1:0] fl_addr;
    logic [15:0] fl_rdata = '0;

    flash_seq_ctrl #(.AW(AW), .ID_WAIT(ID_WAIT), .PROG_LIMIT(PROG_LIMIT),
                     .ERASE_LIMIT(ERASE_LIMIT)) i_flash_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .timeout(timeout), .id_mfr(id_mfr), .id_dev(id_dev), .fl_wr(fl_wr),
        .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int wcnt, nrd, post_rd, bidx, glitch_at, busy_left;
    int last_wr_cyc, first_rd_cyc;
    logic [AW-1:0] wl_a [0:15];
    logic [15:0]   wl_d [0:15];
    logic [AW-1:0] last_rd_addr;
    logic [15:0]   stable_val;
    logic tg, id_mode;
    bit got_done, got_tout;
    int end_cyc;

    // flash model
    always @(posedge clk) begin
        logic [15:0] v;
        cyc = cyc + 1;
        if (fl_wr) begin
            if (wcnt < 16) begin wl_a[wcnt] = fl_addr; wl_d[wcnt] = fl_wdata; end
            wcnt = wcnt + 1;
            last_wr_cyc = cyc;
            if (fl_wdata == 16'h0090) id_mode = 1'b1;
            if (fl_wdata == 16'h00F0) id_mode = 1'b0;
        end
        if (fl_rd) begin
            nrd = nrd + 1;
            last_rd_addr = fl_addr;
            if (nrd == 1) first_rd_cyc = cyc;
            if (id_mode) fl_rdata <= (fl_addr == '0) ? MFR_VAL : DEV_VAL;
            else if (busy_left > 0) begin
                busy_left = busy_left - 1;
                bidx = bidx + 1;
                if (bidx != glitch_at) tg = ~tg;
                v = 16'h0000;
                v[6] = tg;
                fl_rdata <= v;
            end else begin
                post_rd = post_rd + 1;
                fl_rdata <= stable_val;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input int busy_reads, input int glitch, input logic [15:0] stable);
        wcnt = 0; nrd = 0; post_rd = 0; bidx = 0; tg = 1'b0; id_mode = 1'b0;
        busy_left = busy_reads; glitch_at = glitch; stable_val = stable;
        last_wr_cyc = 0; first_rd_cyc = 0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(input int maxc);
        got_done = 0; got_tout = 0;
        for (int i = 0; i < maxc; i++) begin
            if (done) got_done = 1;
            if (timeout) got_tout = 1;
            if (got_done || got_tout) break;
            @(negedge clk);
        end
        end_cyc = cyc;
    endtask

    task automatic expect_wr(input int idx, input logic [AW-1:0] a, input logic [15:0] d, input string tag);
        chk(wl_a[idx] == a, tag, 32'(wl_a[idx]), 32'(a));
        chk(wl_d[idx] == d, tag, 32'(wl_d[idx]), 32'(d));
    endtask

    task automatic expect_unlock5(input string tag);
        expect_wr(0, 21'h555, 16'h00AA, tag);
        expect_wr(1, 21'h2AA, 16'h0055, tag);
        expect_wr(2, 21'h555, 16'h0080, tag);
        expect_wr(3, 21'h555, 16'h00AA, tag);
        expect_wr(4, 21'h2AA, 16'h0055, tag);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !timeout, "R1 reset outputs", {busy, done, timeout}, 0);
        chk(!fl_wr && !fl_rd, "R1 reset strobes", {fl_wr, fl_rd}, 0);
    endtask

    task automatic t_program;
        model_reset(5, -1, 16'h1234);
        issue(3'd0, 21'h1ABCD, 16'h1234);
        wait_end(500);
        chk(wcnt == 4, "R2 program write count", wcnt, 4);
        expect_wr(0, 21'h555, 16'h00AA, "R2 program w0");
        expect_wr(1, 21'h2AA, 16'h0055, "R2 program w1");
        expect_wr(2, 21'h555, 16'h00A0, "R2 program w2");
        expect_wr(3, 21'h1ABCD, 16'h1234, "R2 program w3");
        chk(last_rd_addr == 21'h1ABCD, "R2 poll address", 32'(last_rd_addr), 32'h1ABCD);
        chk(got_done && !got_tout, "R5 program done", {got_done, got_tout}, 2);
        chk(post_rd >= 2, "R5 settled reads before done", post_rd, 2);
        @(negedge clk);
        chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);
    endtask

    task automatic t_sector;
        model_reset(6, -1, 16'h0040);
        issue(3'd1, 21'h12345, 16'h0);
        wait_end(500);
        chk(wcnt == 6, "R3 sector write count", wcnt, 6);
        expect_unlock5("R3 sector unlock");
        expect_wr(5, 21'h12000, 16'h0050, "R3 sector final aligned");
        chk(got_done && post_rd >= 2, "R5 sector done", post_rd, 2);
    endtask

    task automatic t_block_glitch;
        model_reset(10, 4, 16'h0000);
        issue(3'd2, 21'h1ABCD, 16'h0);
        wait_end(500);
        chk(wcnt == 6, "R3 block write count", wcnt, 6);
        expect_unlock5("R3 block unlock");
        expect_wr(5, 21'h18000, 16'h0030, "R3 block final aligned");
        chk(got_done, "R6 block eventually done", got_done, 1);
        chk(post_rd >= 2, "R6 no done on spurious match", post_rd, 2);
    endtask

    task automatic t_chip;
        model_reset(4, -1, 16'hFFFF);
        issue(3'd3, 21'h0777, 16'h0);
        wait_end(800);
        chk(wcnt == 6, "R3 chip write count", wcnt, 6);
        expect_unlock5("R3 chip unlock");
        expect_wr(5, 21'h555, 16'h0010, "R3 chip final");
        chk(got_done && post_rd >= 2, "R5 chip done", post_rd, 2);
    endtask

    task automatic t_read_id;
        int w90;
        model_reset(0, -1, 16'h0);
        issue(3'd4, 21'h0, 16'h0);
        wait_end(200);
        chk(wcnt == 4, "R7 id write count", wcnt, 4);
        expect_wr(0, 21'h555, 16'h00AA, "R7 id w0");
        expect_wr(1, 21'h2AA, 16'h0055, "R7 id w1");
        expect_wr(2, 21'h555, 16'h0090, "R7 id w2");
        expect_wr(3, 21'h0, 16'h00F0, "R7 id exit");
        chk(nrd == 2, "R7 id read count", nrd, 2);
        chk(id_mfr == MFR_VAL, "R7 manufacturer id", id_mfr, MFR_VAL);
        chk(id_dev == DEV_VAL, "R7 device id", id_dev, DEV_VAL);
        chk(got_done, "R7 id done", got_done, 1);
        w90 = first_rd_cyc - (ID_WAIT + 1);
        chk(first_rd_cyc - last_wr_cyc < 0 || w90 >= 0, "R7 sanity", w90, 0);
    endtask

    task automatic t_id_delay;
        int c90;
        model_reset(0, -1, 16'h0);
        issue(3'd4, 21'h0, 16'h0);
        c90 = 0;
        for (int i = 0; i < 20 && c90 == 0; i++) begin
            if (wcnt == 3) c90 = last_wr_cyc;
            @(negedge clk);
        end
        wait_end(200);
        chk(first_rd_cyc - c90 == ID_WAIT + 1, "R7 access delay", first_rd_cyc - c90, ID_WAIT + 1);
    endtask

    task automatic t_timeout(input logic [2:0] op, input int lim, input string tag);
        model_reset(1000000, -1, 16'h0);
        issue(op, 21'h04000, 16'h0BEE);
        wait_end(lim + 100);
        chk(got_tout && !got_done, {tag, " timeout flag"}, {got_tout, got_done}, 2);
        chk(end_cyc - last_wr_cyc == lim, {tag, " timeout cycle"}, end_cyc - last_wr_cyc, lim);
        @(negedge clk);
        chk(!busy && !timeout, {tag, " back to idle"}, {busy, timeout}, 0);
    endtask

    task automatic t_busy_refuse;
        model_reset(20, -1, 16'h0000);
        issue(3'd0, 21'h00100, 16'h0000);
        repeat (2) @(negedge clk);
        chk(busy, "R9 busy during op", busy, 1);
        issue(3'd3, 21'h0, 16'h0);
        wait_end(500);
        chk(wcnt == 4, "R9 refused request no writes", wcnt, 4);
        chk(got_done, "R9 first op completes", got_done, 1);
    endtask

    task automatic t_invalid;
        model_reset(0, -1, 16'h0);
        issue(3'd5, 21'h0, 16'h0);
        repeat (3) @(negedge clk);
        chk(!busy && wcnt == 0 && nrd == 0, "R10 code 5 ignored", wcnt + nrd, 0);
        issue(3'd7, 21'h0, 16'h0);
        repeat (3) @(negedge clk);
        chk(!busy && wcnt == 0, "R10 code 7 ignored", wcnt, 0);
    endtask

    initial begin
        model_reset(0, -1, 16'h0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_sector();
        t_block_glitch();
        t_chip();
        t_read_id();
        t_id_delay();
        t_timeout(3'd0, PROG_LIMIT, "R8 program");
        t_timeout(3'd1, ERASE_LIMIT, "R8 sector");
        t_busy_refuse();
        t_invalid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule